// File: doc/BRIEF.md
# Single-Level Vectored Interrupt Controller

This block decides, once per machine cycle, whether a small 8-bit controller core must break off and call an interrupt handler, and where that handler lives. It watches two sources. The first is an external request line that is active low and level sensitive, so several open-drain devices can pull it down together. The second is an overflow pulse from the core's timer/event counter. The overflow pulse is held in a pending flag until it is serviced. The flag is also cleared if the timer source is disabled.

The request to the core is a valid/ready stream of 12-bit call addresses. `take_valid` rises with `vec_addr` when a source is accepted at an ALE strobe. The controller holds both stable until the core raises `take_ready`, so the core can stall the call for as many cycles as it needs. The handshake cycle (valid and ready both high) marks the interrupt as taken. From that cycle on, the controller is locked and ignores every source. The lock is released only when the core reports a return-with-restore. A plain return leaves the lock set.

The external handler sits at address 3 and the timer handler at address 7. Both are absolute addresses in the lowest 2 KB bank, and the bank bit is always 0. In event-counter mode, with the counter preloaded one below its terminal count, a falling edge on the counter input becomes an extra external-style source at address 7. That case only reaches this block as an overflow pulse.

Top module: `vic_top`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `take_valid` is 0. Reset clears the lockout and the timer pending flag.
- R2: The external line is looked at only in cycles with `ale`=1. A low `ext_req_n` in a cycle with `ale`=0 starts nothing.
- R3: An accepted external request presents `vec_addr` = 12'h003 with `take_valid`=1 after the clock edge that samples it.
- R4: An accepted timer request presents `vec_addr` = 12'h007 with `take_valid`=1 after the clock edge of the ALE cycle, when the pending flag is set and `tmr_en`=1.
- R5: When both sources qualify at the same ALE, 12'h003 is presented. The timer flag stays pending and is served at a later ALE.
- R6: After a handshake (`take_valid`=1 and `take_ready`=1 at a clock edge), `take_valid` stays 0 at every ALE until a return-with-restore (`ret_valid`=1 with `ret_restore`=1) has been seen.
- R7: Bit 11 of `vec_addr` is 0 whenever `take_valid` is 1, so every call lands in bank 0.
- R8: A source whose enable (`ext_en` or `tmr_en`) is 0 at the ALE is never presented.
- R9: While `take_valid`=1 and `take_ready`=0, `take_valid` stays 1 and `vec_addr` stays unchanged in the next cycle.
- R10: The timer pending flag clears when the 12'h007 call is handshaken or when `tmr_en` is 0. An overflow pulse that arrives while `tmr_en`=0 is dropped.
- R11: A return with `ret_restore`=0 leaves the lockout set.
- R12: A one-cycle `tmr_ovf` pulse with `tmr_en`=1 stays pending across ALE strobes, across locked periods, and while the external source wins, until it is served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_req_n | input | 1 | External request, active low, level sensitive, wired-OR |
| ext_en | input | 1 | External source enable |
| tmr_ovf | input | 1 | One-cycle timer/event-counter overflow pulse |
| tmr_en | input | 1 | Timer source enable |
| ale | input | 1 | Machine-cycle strobe; sources are sampled only when high |
| ret_valid | input | 1 | Core executes a return this cycle |
| ret_restore | input | 1 | The return also restores status (return-with-restore) |
| take_valid | output | 1 | Interrupt call request to the core |
| take_ready | input | 1 | Core accepts the call this cycle |
| vec_addr | output | 12 | Call target address, bank 0 |

## Verification
A wrong lockout state shows up at the first ALE after a handshake. If the lock failed to set, or a plain return cleared it, a second `take_valid` rises at that strobe. If the lock failed to clear, no request rises at the first ALE after a return-with-restore. A corrupted pending flag shows one strobe after the overflow: either a 12'h007 call appears that should not, or an expected one does not appear. A wrong vector or broken back-pressure is visible at the port in the very cycle it happens.

// File: rtl/vic_pkg.sv
package vic_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_EXT  = 2'd1,
    SRC_TMR  = 2'd2
  } vic_src_e;

  // Place a handler address into the lowest bank by clearing the bank bit.
  function automatic logic [31:0] bank0_addr(input logic [31:0] a, input int bank_bit);
    logic [31:0] m;
    m = 32'd1 << bank_bit;
    return a & ~m;
  endfunction
endpackage

// File: rtl/vic_pend.sv
// Timer overflow pending latch (R10, R12).
module vic_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf,
  input  logic en,
  input  logic served,
  output logic pend
);
  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend_q <= 1'b0;
    else if (!en)    pend_q <= 1'b0;
    else if (ovf)    pend_q <= 1'b1;
    else if (served) pend_q <= 1'b0;
  end

  assign pend = pend_q;
endmodule

// File: rtl/vic_lock.sv
// Single-level lockout: set on handshake, released only by return-with-restore (R6, R11).
module vic_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic taken,
  input  logic ret_valid,
  input  logic ret_restore,
  output logic locked
);
  logic lock_q;
  logic release_w;

  assign release_w = ret_valid & ret_restore;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         lock_q <= 1'b0;
    else if (taken)     lock_q <= 1'b1;
    else if (release_w) lock_q <= 1'b0;
  end

  assign locked = lock_q;
endmodule

// File: rtl/vic_arb.sv
// Samples sources at ALE, applies priority, holds the call until accepted (R2-R5, R7-R9).
module vic_arb
  import vic_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int EXT_VEC  = 3,
  parameter int TMR_VEC  = 7,
  parameter int BANK_BIT = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ale,
  input  logic              ext_act,
  input  logic              ext_en,
  input  logic              tmr_pend,
  input  logic              tmr_en,
  input  logic              locked,
  input  logic              ready,
  output logic              valid,
  output logic [ADDR_W-1:0] vec,
  output vic_src_e          src
);
  localparam logic [31:0]       EXT_FULL = bank0_addr(EXT_VEC, BANK_BIT);
  localparam logic [31:0]       TMR_FULL = bank0_addr(TMR_VEC, BANK_BIT);
  localparam logic [ADDR_W-1:0] EXT_A    = EXT_FULL[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] TMR_A    = TMR_FULL[ADDR_W-1:0];

  logic     valid_q;
  vic_src_e src_q;
  logic     ext_ok;
  logic     tmr_ok;
  logic     open_w;

  assign open_w = ale & ~locked & ~valid_q;
  assign ext_ok = ext_act & ext_en;
  assign tmr_ok = tmr_pend & tmr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      src_q   <= SRC_NONE;
    end else if (valid_q) begin
      if (ready) begin
        valid_q <= 1'b0;
        src_q   <= SRC_NONE;
      end
    end else if (open_w) begin
      if (ext_ok) begin
        valid_q <= 1'b1;
        src_q   <= SRC_EXT;
      end else if (tmr_ok) begin
        valid_q <= 1'b1;
        src_q   <= SRC_TMR;
      end
    end
  end

  always_comb begin
    unique case (src_q)
      SRC_EXT: vec = EXT_A;
      SRC_TMR: vec = TMR_A;
      default: vec = '0;
    endcase
  end

  assign valid = valid_q;
  assign src   = src_q;
endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int EXT_VEC  = 3,
  parameter int TMR_VEC  = 7,
  parameter int BANK_BIT = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_req_n,
  input  logic              ext_en,
  input  logic              tmr_ovf,
  input  logic              tmr_en,
  input  logic              ale,
  input  logic              ret_valid,
  input  logic              ret_restore,
  output logic              take_valid,
  input  logic              take_ready,
  output logic [ADDR_W-1:0] vec_addr
);
  logic     locked;
  logic     tmr_pend;
  logic     taken;
  logic     tmr_served;
  vic_src_e cur_src;

  assign taken      = take_valid & take_ready;
  assign tmr_served = taken & (cur_src == SRC_TMR);

  vic_pend u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .ovf    (tmr_ovf),
    .en     (tmr_en),
    .served (tmr_served),
    .pend   (tmr_pend)
  );

  vic_lock u_lock (
    .clk         (clk),
    .rst_n       (rst_n),
    .taken       (taken),
    .ret_valid   (ret_valid),
    .ret_restore (ret_restore),
    .locked      (locked)
  );

  vic_arb #(
    .ADDR_W   (ADDR_W),
    .EXT_VEC  (EXT_VEC),
    .TMR_VEC  (TMR_VEC),
    .BANK_BIT (BANK_BIT)
  ) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .ale      (ale),
    .ext_act  (~ext_req_n),
    .ext_en   (ext_en),
    .tmr_pend (tmr_pend),
    .tmr_en   (tmr_en),
    .locked   (locked),
    .ready    (take_ready),
    .valid    (take_valid),
    .vec      (vec_addr),
    .src      (cur_src)
  );
endmodule

// File: rtl/vic_checker.sv
module vic_checker #(
  parameter int ADDR_W   = 12,
  parameter int EXT_VEC  = 3,
  parameter int TMR_VEC  = 7,
  parameter int BANK_BIT = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ext_req_n,
  input logic              ext_en,
  input logic              tmr_en,
  input logic              ale,
  input logic              ret_valid,
  input logic              ret_restore,
  input logic              take_valid,
  input logic              take_ready,
  input logic [ADDR_W-1:0] vec_addr,
  input logic              locked,
  input logic              tmr_pend
);
  localparam logic [ADDR_W-1:0] EA = ADDR_W'(EXT_VEC);
  localparam logic [ADDR_W-1:0] TA = ADDR_W'(TMR_VEC);

  p_bank0_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid |-> (!vec_addr[BANK_BIT] && (vec_addr == EA || vec_addr == TA)));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (take_valid && !take_ready) |=> (take_valid && $stable(vec_addr)));

  p_lockout_r6: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> !$rose(take_valid));

  p_plain_ret_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && ret_valid && !ret_restore && !take_valid) |=> locked);

  p_ext_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(take_valid) && vec_addr == EA) |-> $past(ext_en && !ext_req_n && ale));

  p_prio_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(take_valid) && $past(ext_en && !ext_req_n)) |-> (vec_addr == EA));

  p_tmr_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_en |=> !tmr_pend);
endmodule

bind vic_top vic_checker #(
  .ADDR_W   (ADDR_W),
  .EXT_VEC  (EXT_VEC),
  .TMR_VEC  (TMR_VEC),
  .BANK_BIT (BANK_BIT)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ext_req_n   (ext_req_n),
  .ext_en      (ext_en),
  .tmr_en      (tmr_en),
  .ale         (ale),
  .ret_valid   (ret_valid),
  .ret_restore (ret_restore),
  .take_valid  (take_valid),
  .take_ready  (take_ready),
  .vec_addr    (vec_addr),
  .locked      (locked),
  .tmr_pend    (tmr_pend)
);

// File: tb/tb_vic_top.sv
module tb_vic_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_req_n = 1'b1, ext_en = 1'b0, tmr_ovf = 1'b0, tmr_en = 1'b0;
  logic        ale = 1'b0, ret_valid = 1'b0, ret_restore = 1'b0, take_ready = 1'b0;
  logic        take_valid;
  logic [11:0] vec_addr;
  int          n_chk = 0;
  int          n_bad = 0;

  always #2 clk = ~clk;

  vic_top dut (
    .clk(clk), .rst_n(rst_n), .ext_req_n(ext_req_n), .ext_en(ext_en),
    .tmr_ovf(tmr_ovf), .tmr_en(tmr_en), .ale(ale), .ret_valid(ret_valid),
    .ret_restore(ret_restore), .take_valid(take_valid), .take_ready(take_ready),
    .vec_addr(vec_addr)
  );

  typedef struct packed {
    logic       ext_n, eena, ovf, tena, ale, rdy, rv, rr, ev;
    logic [11:0] evec;
    logic [3:0]  req;
  } step_t;

  localparam int NSTEP = 29;
  // fields: ext_n eena ovf tena ale rdy rv rr | exp_valid exp_vec | req
  localparam step_t TBL [NSTEP] = '{
    '{1,1,0,1,1,0,0,0, 0,12'h000, 4'd1 },  // R1 idle after reset
    '{0,1,0,1,0,0,0,0, 0,12'h000, 4'd2 },  // R2 no ALE, no sample
    '{0,1,0,1,1,0,0,0, 1,12'h003, 4'd3 },  // R3 external call
    '{1,1,0,1,0,0,0,0, 1,12'h003, 4'd9 },  // R9 held under back-pressure
    '{1,1,0,1,0,1,0,0, 0,12'h000, 4'd6 },  // R6 handshake
    '{0,1,0,1,1,0,0,0, 0,12'h000, 4'd6 },  // R6 locked
    '{0,1,0,1,1,0,1,0, 0,12'h000, 4'd11},  // R11 plain return
    '{0,1,0,1,0,0,1,1, 0,12'h000, 4'd6 },  // R6 restore return
    '{0,1,0,1,1,0,0,0, 1,12'h003, 4'd6 },  // R6 reopened
    '{1,1,0,1,0,1,0,0, 0,12'h000, 4'd6 },
    '{1,1,0,1,0,0,1,1, 0,12'h000, 4'd6 },
    '{1,1,1,1,0,0,0,0, 0,12'h000, 4'd12},  // R12 overflow pulse
    '{1,1,0,1,1,0,0,0, 1,12'h007, 4'd4 },  // R4 timer call
    '{1,1,0,1,0,1,0,0, 0,12'h000, 4'd4 },
    '{1,1,0,1,0,0,1,1, 0,12'h000, 4'd6 },
    '{1,1,0,1,1,0,0,0, 0,12'h000, 4'd10},  // R10 cleared by service
    '{1,1,1,1,0,0,0,0, 0,12'h000, 4'd12},
    '{0,1,0,1,1,0,0,0, 1,12'h003, 4'd5 },  // R5 external first
    '{1,1,0,1,0,1,0,0, 0,12'h000, 4'd5 },
    '{1,1,0,1,0,0,1,1, 0,12'h000, 4'd6 },
    '{1,1,0,1,1,0,0,0, 1,12'h007, 4'd5 },  // R5 timer still pending
    '{1,1,0,1,0,1,0,0, 0,12'h000, 4'd4 },
    '{1,1,0,1,0,0,1,1, 0,12'h000, 4'd6 },
    '{0,0,0,1,1,0,0,0, 0,12'h000, 4'd8 },  // R8 external disabled
    '{1,0,1,1,0,0,0,0, 0,12'h000, 4'd12},
    '{1,0,0,0,0,0,0,0, 0,12'h000, 4'd10},  // R10 disable clears
    '{1,0,0,1,1,0,0,0, 0,12'h000, 4'd10},
    '{1,0,1,0,0,0,0,0, 0,12'h000, 4'd10},  // R10 pulse dropped
    '{1,0,0,1,1,0,0,0, 0,12'h000, 4'd10}
  };

  task automatic check(input logic ev, input logic [11:0] evec, input int req);
    n_chk++;
    if (take_valid !== ev || (ev && (vec_addr !== evec || vec_addr[11] !== 1'b0))) begin
      n_bad++;
      $display("FAIL R%0d: valid=%b vec=%h expected valid=%b vec=%h",
               req, take_valid, vec_addr, ev, evec);
    end
  endtask

  task automatic drive(input step_t s);
    ext_req_n = s.ext_n; ext_en = s.eena; tmr_ovf = s.ovf; tmr_en = s.tena;
    ale = s.ale; take_ready = s.rdy; ret_valid = s.rv; ret_restore = s.rr;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    drive('{1,1,0,1,0,0,0,0, 0,12'h000, 4'd0});
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(1'b0, 12'h000, 1);  // R1 output low in reset
    rst_n = 1'b1;
    @(negedge clk);
    check(1'b0, 12'h000, 1);  // R1 first cycle after reset

    for (int i = 0; i < NSTEP; i++) begin
      drive(TBL[i]);
      check(TBL[i].ev, TBL[i].evec, int'(TBL[i].req));
    end

    // R1: reset while locked and with a timer pending clears both
    drive('{1,1,1,1,0,0,0,0, 0,12'h000, 4'd0});
    drive('{0,1,0,1,1,0,0,0, 0,12'h000, 4'd0});
    check(1'b1, 12'h003, 3);
    drive('{1,1,0,1,0,1,0,0, 0,12'h000, 4'd0});  // now locked, timer pending
    rst_n = 1'b0;
    @(negedge clk);
    check(1'b0, 12'h000, 1);
    rst_n = 1'b1;
    drive('{1,1,0,1,1,0,0,0, 0,12'h000, 4'd0});
    check(1'b0, 12'h000, 1);  // R1 pending flag gone
    drive('{0,1,0,1,1,0,0,0, 0,12'h000, 4'd0});
    check(1'b1, 12'h003, 1);  // R1 lockout gone

    // R9: long stall keeps the timer call stable
    drive('{1,1,0,1,0,1,0,0, 0,12'h000, 4'd0});
    drive('{1,1,0,1,0,0,1,1, 0,12'h000, 4'd0});
    drive('{1,1,1,1,0,0,0,0, 0,12'h000, 4'd0});
    drive('{1,1,0,1,1,0,0,0, 0,12'h000, 4'd0});
    for (int k = 0; k < 5; k++) begin
      drive('{0,1,0,1,1,0,0,0, 0,12'h000, 4'd0});
      check(1'b1, 12'h007, 9);
    end
    idle();
    check(1'b1, 12'h007, 9);
    finish_run();
  end
endmodule